// File: doc/BRIEF.md
# Core Tick Timer with Match Compare

This block is a free-running cycle counter paired with a control word that holds a match value, an interrupt enable, an interrupt pending flag and a run mode. The counter advances on every core clock while it is running. When the counter's low bits equal the stored match value, the pending flag sets. If interrupts are enabled, a level interrupt then goes to the core. In the free-running mode the counter runs through a match without stopping, so one block can serve two purposes: a monotonic time base that software reads at any moment, and a one-shot event source that software re-arms by writing a new match value.

Software reaches the block through a plain register port with an address, a write strobe, write data and combinational read data. The port has no back-pressure. A write is always taken on the clock edge where the strobe is high, and read data is valid in the same cycle as its address. There are three addresses: the counter, the control word, and a read-only capability word. Its flag shows that the timer is present. The counter width `W` is a parameter with a default of 32. The match field is `W-4` bits wide.

Top module: `tick_timer`

## Requirements
- R1: A synchronous active-high reset clears the counter, the whole control word and the interrupt output.
- R2: When the run mode (control bits [W-1:W-2]) is 2'b11, the counter rises by one on every clock. It wraps from 2^W-1 to 0 and keeps counting through a match.
- R3: When the run mode is 2'b00, the counter holds its value and no match is detected.
- R4: In any mode other than 2'b00, a match occurs when counter bits [W-5:0] equal the match field (control bits [W-5:0]). The upper four counter bits play no part. The pending flag (control bit W-4) reads 1 from the cycle after the match.
- R5: When the run mode is 2'b01, the counter loads zero on the edge where a match is present, and then counts on from zero.
- R6: When the run mode is 2'b10, the counter stops at the matching value and stays there.
- R7: The interrupt output is high exactly while both the pending flag and the enable bit (control bit W-3) are 1. With the enable bit at 0, a match still sets the pending flag but the interrupt stays low.
- R8: Every write to the control word (address 1) replaces the mode, the enable and the match field. Writing 0 to the pending position clears the flag. Writing 1 leaves the flag unchanged, so a write can never set it. If a match occurs in the same cycle as such a write, the match wins.
- R9: A write to the control word never disturbs the counter. Writing only the run mode clears the enable and the pending flag while counting carries on.
- R10: A write to the counter (address 0) loads the written value on that edge, and this takes priority over the increment, the restart and the stop.
- R11: Address 2 reads a capability word in which only bit PRESENT_BIT (default 10) is 1. Writes to it are ignored, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 counter, 1 control, 2 capability |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Combinational read data for reg_addr |
| irq_o | output | 1 | Level interrupt to the core |

## Verification
The checker watches the counter step in each run mode on every cycle: increment, hold, reload to zero and stop. It also checks that a counter write wins, that a control write leaves the count untouched, and that the pending flag rises only after a match and always after one. What these properties cannot show is handled by the bench scenarios. These cover the arithmetic distance from an armed counter to its match across several match values and starting counts, wrap-around at the top of the counter, the ordering of acknowledge and re-arm writes, and the capability word staying fixed against writes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    RUN_OFF     = 2'b00,
    RUN_RESTART = 2'b01,
    RUN_HALT    = 2'b10,
    RUN_FREE    = 2'b11
  } run_mode_e;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_CAPS  = 2'd2;
endpackage

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg
  import tick_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          match_hit,
  output run_mode_e     run_mode,
  output logic          ie,
  output logic          pend,
  output logic [W-5:0]  match_val
);
  localparam int MW       = W - 4;
  localparam int IE_BIT   = W - 3;
  localparam int PEND_BIT = W - 4;

  logic pend_kept;

  // A write can only keep or clear the flag; a match always sets it.
  always_comb begin
    pend_kept = wr ? (pend & wdata[PEND_BIT]) : pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_mode  <= RUN_OFF;
      ie        <= 1'b0;
      pend      <= 1'b0;
      match_val <= '0;
    end else begin
      if (wr) begin
        run_mode  <= run_mode_e'(wdata[W-1:W-2]);
        ie        <= wdata[IE_BIT];
        match_val <= wdata[MW-1:0];
      end
      pend <= pend_kept | match_hit;
    end
  end
endmodule

// File: rtl/tick_compare.sv
module tick_compare
  import tick_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] count,
  input  logic [W-5:0] match_val,
  input  run_mode_e    run_mode,
  output logic         match_hit
);
  localparam int MW = W - 4;

  always_comb begin
    match_hit = (run_mode != RUN_OFF) && (count[MW-1:0] == match_val);
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  run_mode_e    run_mode,
  input  logic         match_hit,
  output logic [W-1:0] count
);
  logic [W-1:0] count_nx;

  always_comb begin
    count_nx = count;
    if (wr) begin
      count_nx = wdata;
    end else begin
      unique case (run_mode)
        RUN_OFF:     count_nx = count;
        RUN_RESTART: count_nx = match_hit ? '0 : count + W'(1);
        RUN_HALT:    count_nx = match_hit ? count : count + W'(1);
        RUN_FREE:    count_nx = count + W'(1);
        default:     count_nx = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nx;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int W           = 32,
  parameter int PRESENT_BIT = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq_o
);
  localparam int MW = W - 4;
  localparam logic [W-1:0] CAPS_WORD = W'(1) << PRESENT_BIT;

  logic          count_wr;
  logic          ctrl_wr;
  logic [W-1:0]  count_q;
  run_mode_e     mode_q;
  logic          ie_q;
  logic          pend_q;
  logic [MW-1:0] match_q;
  logic          hit;

  assign count_wr = reg_wr && (reg_addr == ADDR_COUNT);
  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);

  tick_counter #(.W(W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .wr        (count_wr),
    .wdata     (reg_wdata),
    .run_mode  (mode_q),
    .match_hit (hit),
    .count     (count_q)
  );

  tick_compare #(.W(W)) u_cmp (
    .count     (count_q),
    .match_val (match_q),
    .run_mode  (mode_q),
    .match_hit (hit)
  );

  tick_ctrl_reg #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctrl_wr),
    .wdata     (reg_wdata),
    .match_hit (hit),
    .run_mode  (mode_q),
    .ie        (ie_q),
    .pend      (pend_q),
    .match_val (match_q)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_COUNT: reg_rdata = count_q;
      ADDR_CTRL:  reg_rdata = {mode_q, ie_q, pend_q, match_q};
      ADDR_CAPS:  reg_rdata = CAPS_WORD;
      default:    reg_rdata = '0;
    endcase
  end

  assign irq_o = pend_q & ie_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] cnt,
  input logic [1:0]   mode,
  input logic         pend,
  input logic         hit
);
  logic cnt_wr;
  logic ctl_wr;
  assign cnt_wr = reg_wr && (reg_addr == 2'd0);
  assign ctl_wr = reg_wr && (reg_addr == 2'd1);

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !cnt_wr) |=> cnt == $past(cnt) + W'(1)); // R2
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !cnt_wr) |=> $stable(cnt)); // R3
  AST_MATCH_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    hit |=> pend); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && hit && !cnt_wr) |=> cnt == '0); // R5
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && hit && !cnt_wr) |=> $stable(cnt)); // R6
  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(hit)); // R8
  AST_CTRL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && mode == 2'b00) |=> $stable(cnt)); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt == $past(reg_wdata)); // R10
endmodule

bind tick_timer tick_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cnt       (count_q),
  .mode      (mode_q),
  .pend      (pend_q),
  .hit       (hit)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int W  = 12;
  localparam int MW = W - 4;
  localparam int PB = 10;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   reg_addr = 2'd0;
  logic         reg_wr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_timer #(.W(W), .PRESENT_BIT(PB)) i_tick_timer (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  function automatic logic [W-1:0] ctl(int mode, int ie, int pend, int m);
    return {2'(mode), 1'(ie), 1'(pend), MW'(m)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    int v, c, d, x;
    int cs[4];
    int ms[4];
    cs = '{0, 'h7F5, 'hAFE, 'hFFE};
    ms = '{'h00, 'h01, 'h80, 'hFF};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); check(v == 0, "R1 count", v, 0);
    rd(2'd1, v); check(v == 0, "R1 ctrl", v, 0);
    check(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);

    // R3 disabled mode: count holds, no match even when low bits equal
    repeat (10) @(negedge clk);
    rd(2'd0, v); check(v == 0, "R3 hold after reset", v, 0);
    wr(2'd0, 12'h305);
    wr(2'd1, ctl(0, 1, 0, 'h05));
    repeat (5) @(negedge clk);
    rd(2'd0, v); check(v == 'h305, "R3 hold", v, 'h305);
    rd(2'd1, v); check(v[MW] == 1'b0, "R3 no pend", v[MW], 0);

    // R11 capability word
    rd(2'd2, v); check(v == (1 << PB), "R11 caps", v, 1 << PB);
    wr(2'd2, '0);
    rd(2'd2, v); check(v == (1 << PB), "R11 caps write ignored", v, 1 << PB);
    rd(2'd3, v); check(v == 0, "R11 addr3", v, 0);

    // R2 R4 R7 sweep: start count x match value in free-running mode
    foreach (cs[i]) begin
      foreach (ms[j]) begin
        wr(2'd1, ctl(0, 0, 0, 0));
        wr(2'd0, W'(cs[i]));
        wr(2'd1, ctl(3, 1, 0, ms[j]));
        d = (ms[j] - cs[i]) & ((1 << MW) - 1);
        repeat (d) @(negedge clk);
        rd(2'd1, v); check(v[MW] == 1'b0, "R4 pend before match", v[MW], 0);
        @(negedge clk);
        rd(2'd1, v); check(v[MW] == 1'b1, "R4 pend after match", v[MW], 1);
        check(irq_o == 1'b1, "R7 irq raised", int'(irq_o), 1);
        rd(2'd0, v);
        x = (cs[i] + d + 1) % MOD;
        check(v == x, "R2 count runs through match", v, x);
      end
    end

    // R8 R9 acknowledge by writing only the run mode; count keeps going
    rd(2'd0, c);
    wr(2'd1, ctl(3, 0, 0, 0));
    rd(2'd0, v); check(v == (c + 1) % MOD, "R9 count undisturbed", v, (c + 1) % MOD);
    rd(2'd1, v); check(v[MW+1:MW] == 2'b00, "R8 ack clears pend and ie", v[MW+1:MW], 0);
    check(irq_o == 1'b0, "R7 irq after ack", int'(irq_o), 0);

    // R8 a write cannot set pending
    rd(2'd0, c);
    wr(2'd1, ctl(3, 1, 1, (c + 100) & 'hFF));
    rd(2'd1, v); check(v[MW] == 1'b0, "R8 write cannot set", v[MW], 0);
    check(irq_o == 1'b0, "R7 no irq without pend", int'(irq_o), 0);

    // R7 enable low: pending sets, irq stays low
    wr(2'd1, ctl(0, 0, 0, 0));
    wr(2'd0, 12'h010);
    wr(2'd1, ctl(3, 0, 0, 'h14));
    repeat (5) @(negedge clk);
    rd(2'd1, v); check(v[MW] == 1'b1, "R7 pend with ie low", v[MW], 1);
    check(irq_o == 1'b0, "R7 irq masked", int'(irq_o), 0);

    // R10 counter write while free-running
    wr(2'd0, 12'h123);
    rd(2'd0, v); check(v == 'h123, "R10 write priority", v, 'h123);

    // R2 wrap
    wr(2'd1, ctl(0, 0, 0, 0));
    wr(2'd0, 12'hFFE);
    wr(2'd1, ctl(3, 0, 0, 'h80));
    repeat (5) @(negedge clk);
    rd(2'd0, v); check(v == 3, "R2 wrap", v, 3);

    // R5 restart mode
    wr(2'd1, ctl(0, 0, 0, 0));
    wr(2'd0, 12'h520);
    wr(2'd1, ctl(1, 1, 0, 'h30));
    repeat (17) @(negedge clk);
    rd(2'd0, v); check(v == 0, "R5 restart to zero", v, 0);
    repeat (3) @(negedge clk);
    rd(2'd0, v); check(v == 3, "R5 counts from zero", v, 3);

    // R6 halt mode
    wr(2'd1, ctl(0, 0, 0, 0));
    wr(2'd0, 12'h240);
    wr(2'd1, ctl(2, 0, 0, 'h48));
    repeat (8) @(negedge clk);
    rd(2'd0, v); check(v == 'h248, "R6 reaches match", v, 'h248);
    repeat (6) @(negedge clk);
    rd(2'd0, v); check(v == 'h248, "R6 stays stopped", v, 'h248);
    rd(2'd1, v); check(v[MW] == 1'b1, "R6 pend set", v[MW], 1);

    done = 1'b1;
    summary();
  end
endmodule